// File: doc/BRIEF.md
# Indirect Banked Test-Register Access

This block sits behind a management register decoder inside a PHY. It gives a host a path to hidden banks of test registers through three directly addressed registers: a control register, a read-data window and a write-data window. The hidden banks are closed after reset. A fixed sequence of four writes to the control register opens them. Once they are open, one control word carries a read strobe, a write strobe, a bank number and two register addresses, and moves one 16-bit value between a window and the selected bank register.

The host side is a plain single-cycle register port of the kind an MDIO frame decoder presents: a write enable, a 5-bit direct address, write data, and combinational read data. There are four bank slots. Slot 2 is left empty. Reads of slot 2 give zero and writes to it are dropped. Each of the other slots holds 32 registers of 16 bits.

Top module: `hba_test_window`

## Requirements
- R1: After reset the banks are locked. Direct reads of addresses 20, 21 and 23 return 0, and every bank register holds 0.
- R2: The banks unlock only after four consecutive writes to address 20 of 0x0000, 0x0400, 0x0000, 0x0400. A write of 0x0000 always restarts the sequence. Any other control write returns the sequence tracker to idle.
- R3: While unlocked, a control write of 0x0000, or of any word with bit 10 (test mode) clear, locks the banks again.
- R4: While locked, read and write strobes have no effect on the read window or on any bank register.
- R5: In an unlocked control write with bit 10 set, bit 15 is the read strobe, bits 12:11 select the bank and bits 9:5 give the read address. The addressed bank register is copied into the read window at the clock edge of that write, and address 21 shows it from the next cycle.
- R6: Address 23 is a write-data window that reads back its last written value. In an unlocked control write with bit 10 set and bit 14 (write strobe) set, the window value is stored into bank[bits 12:11] register[bits 4:0] at that edge.
- R7: When both strobes are set in one control word, the read captures the register contents from before the write in that same word.
- R8: Bank 2 has no storage. A read strobe on it loads 0 into the read window, and a write strobe on it changes nothing.
- R9: Address 20 reads back the last control word written. Writes to address 21 are ignored. All other direct addresses read 0.
- R10: A write strobe changes only the one addressed register in the one selected bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Direct register write enable |
| reg_addr | input | 5 | Direct register address |
| reg_wdata | input | 16 | Direct register write data |
| reg_rdata | output | 16 | Direct register read data (combinational) |

## Verification
A bank read and a bank write can happen at the same clock edge when one control word sets both strobes. If the two addresses match, the read must see the old value. The bench provokes this with a directed word that reads and writes the same register of bank 3. Its random phase also sets both strobes with addresses drawn at random. The read window is compared against a bench model that performs the read before the write, and a later read of the same register shows that the write landed.

// File: rtl/hba_pkg.sv
// Package: shared constants and types for the banked test-register window.
// Assumes a 16-bit management data path and 5-bit direct addressing.
package hba_pkg;
    localparam int DATA_W      = 16;
    localparam int DADDR_W     = 5;
    localparam int BANK_SEL_W  = 2;
    localparam int REG_ADDR_W  = 5;
    localparam int NUM_BANKS   = 1 << BANK_SEL_W;
    localparam int BANK_DEPTH  = 1 << REG_ADDR_W;

    // Direct addresses of the access window
    localparam logic [DADDR_W-1:0] A_CTL   = 5'd20;
    localparam logic [DADDR_W-1:0] A_RDWIN = 5'd21;
    localparam logic [DADDR_W-1:0] A_WRWIN = 5'd23;

    // Control word as seen by the decoder, most significant field first
    typedef struct packed {
        logic                  rd_go;
        logic                  wr_go;
        logic                  rsvd;
        logic [BANK_SEL_W-1:0] bank;
        logic                  tmode;
        logic [REG_ADDR_W-1:0] rd_reg;
        logic [REG_ADDR_W-1:0] wr_reg;
    } ctl_word_t;

    localparam logic [DATA_W-1:0] TMODE_ONLY = 16'h0400;

    // Progress through the unlock pattern
    typedef enum logic [2:0] {
        UL_IDLE  = 3'd0,
        UL_Z1    = 3'd1,
        UL_T1    = 3'd2,
        UL_Z2    = 3'd3,
        UL_OPEN  = 3'd4
    } unlock_st_t;
endpackage

// File: rtl/hba_unlock_fsm.sv
// Module: hba_unlock_fsm
// Follows control-register writes and decides when the hidden banks are open.
// Assumes ctl_wr pulses for one cycle per control write; ctl_data is valid with it.
module hba_unlock_fsm
    import hba_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_data,
    output logic              unlocked
);
    unlock_st_t st_q, st_d;
    logic       is_zero, is_tm_only;

    // Classify the written word
    always_comb begin
        is_zero    = (ctl_data == '0);
        is_tm_only = (ctl_data == TMODE_ONLY);
    end

    // Next-state logic for the unlock pattern
    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            if (st_q == UL_OPEN) begin
                if (!ctl_data[10])
                    st_d = is_zero ? UL_Z1 : UL_IDLE;
            end else if (is_zero) begin
                st_d = (st_q == UL_T1) ? UL_Z2 : UL_Z1;
            end else if (is_tm_only) begin
                case (st_q)
                    UL_Z1:   st_d = UL_T1;
                    UL_Z2:   st_d = UL_OPEN;
                    default: st_d = UL_IDLE;
                endcase
            end else begin
                st_d = UL_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign unlocked = (st_q == UL_OPEN);
endmodule

// File: rtl/hba_ctl_decode.sv
// Module: hba_ctl_decode
// Splits a control write into qualified bank read and write requests.
// Assumes `unlocked` is the state before this write's clock edge.
module hba_ctl_decode
    import hba_pkg::*;
(
    input  logic                  ctl_wr,
    input  logic [DATA_W-1:0]     ctl_data,
    input  logic                  unlocked,
    output logic                  rd_req,
    output logic                  wr_req,
    output logic [BANK_SEL_W-1:0] bank,
    output logic [REG_ADDR_W-1:0] rd_reg,
    output logic [REG_ADDR_W-1:0] wr_reg
);
    ctl_word_t w;
    logic      go_ok;
    logic      unused_rsvd;

    // Field extraction and qualification by lock state and test mode
    always_comb begin
        w           = ctl_word_t'(ctl_data);
        go_ok       = ctl_wr && unlocked && w.tmode;
        rd_req      = go_ok && w.rd_go;
        wr_req      = go_ok && w.wr_go;
        bank        = w.bank;
        rd_reg      = w.rd_reg;
        wr_reg      = w.wr_reg;
        unused_rsvd = w.rsvd;
    end
endmodule

// File: rtl/hba_reg_bank.sv
// Module: hba_reg_bank
// One hidden bank: DEPTH registers, one synchronous write port and one
// combinational read port. Assumes wr_en is already qualified.
module hba_reg_bank #(
    parameter int WIDTH  = 16,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Storage with reset to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/hba_test_window.sv
// Module: hba_test_window (top)
// Direct register window (control, read data, write data) in front of
// banked test registers. BANK_PRESENT marks which bank slots hold storage;
// an empty slot reads 0 and drops writes. Assumes a single-cycle register
// port with combinational read data.
module hba_test_window
    import hba_pkg::*;
#(
    parameter logic [NUM_BANKS-1:0] BANK_PRESENT = 4'b1011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [DADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    logic                  ctl_wr;
    logic [DATA_W-1:0]     ctl_q;
    logic [DATA_W-1:0]     rd_win;
    logic [DATA_W-1:0]     wr_win;
    logic                  unlocked;
    logic                  rd_req, wr_req;
    logic [BANK_SEL_W-1:0] bank;
    logic [REG_ADDR_W-1:0] rd_reg, wr_reg;
    logic [NUM_BANKS-1:0]  bank_we;
    logic [DATA_W-1:0]     bank_rdata [NUM_BANKS];

    assign ctl_wr = reg_wr && (reg_addr == A_CTL);

    hba_unlock_fsm u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_data (reg_wdata),
        .unlocked (unlocked)
    );

    hba_ctl_decode u_decode (
        .ctl_wr   (ctl_wr),
        .ctl_data (reg_wdata),
        .unlocked (unlocked),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .bank     (bank),
        .rd_reg   (rd_reg),
        .wr_reg   (wr_reg)
    );

    // One bank instance per populated slot, constant zero otherwise
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (BANK_PRESENT[b]) begin : g_fill
            assign bank_we[b] = wr_req && (bank == BANK_SEL_W'(b));
            hba_reg_bank #(
                .WIDTH (DATA_W),
                .DEPTH (BANK_DEPTH)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bank_we[b]),
                .wr_addr (wr_reg),
                .wr_data (wr_win),
                .rd_addr (rd_reg),
                .rd_data (bank_rdata[b])
            );
        end else begin : g_empty
            assign bank_we[b]    = 1'b0;
            assign bank_rdata[b] = '0;
        end
    end

    // Control register shadow for read-back
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= reg_wdata;
    end

    // Write-data window
    always_ff @(posedge clk) begin
        if (!rst_n)                             wr_win <= '0;
        else if (reg_wr && reg_addr == A_WRWIN) wr_win <= reg_wdata;
    end

    // Read-data window, loaded by a qualified read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_win <= '0;
        else if (rd_req) rd_win <= bank_rdata[bank];
    end

    // Direct read mux
    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = ctl_q;
            A_RDWIN: reg_rdata = rd_win;
            A_WRWIN: reg_rdata = wr_win;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hba_test_window_chk.sv
// Module: hba_test_window_chk
// Temporal checks on the window block, attached by bind below.
module hba_test_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [4:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        unlocked,
    input logic [15:0] rd_win,
    input logic        any_we
);
    logic ctl_wr;
    assign ctl_wr = reg_wr && (reg_addr == 5'd20);

    // R2: opening is always caused by a test-mode-only control write
    p_open_by_tm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(ctl_wr && reg_wdata == 16'h0400));

    // R3: a zero control write leaves the banks locked
    p_zero_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata == 16'h0000) |=> !unlocked);

    // R4: no bank commit while locked
    p_no_commit_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !any_we);

    // R5: read window changes only on a control write
    p_rdwin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(rd_win));

    // R8: a read of the empty bank loads zero
    p_bank2_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && unlocked && reg_wdata[15] && reg_wdata[10] &&
         reg_wdata[12:11] == 2'd2) |=> (rd_win == 16'h0000));
endmodule

bind hba_test_window hba_test_window_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .unlocked  (unlocked),
    .rd_win    (rd_win),
    .any_we    (|bank_we)
);

// File: tb/test_hba_test_window.sv
// Bench for hba_test_window: directed corners followed by seeded random
// traffic, checked against a behavioural model built from the requirements.
module test_hba_test_window;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [15:0] m_mem [4][32];
    logic [15:0] m_ctl, m_rd, m_wr;
    int          m_st;   // 0 idle, 1 saw 0, 2 saw 0/TM, 3 saw 0/TM/0, 4 open

    always #(CLK_PERIOD/2) clk = ~clk;

    hba_test_window i_hba_test_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [15:0] mk(bit rd, bit wr, int bank, bit tm, int ra, int wa);
        return {rd, wr, 1'b0, 2'(bank), tm, 5'(ra), 5'(wa)};
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 32; r++) m_mem[b][r] = '0;
        m_ctl = '0; m_rd = '0; m_wr = '0; m_st = 0;
    endtask

    // Model of one direct write, following R2..R10
    task automatic model_write(logic [4:0] a, logic [15:0] w);
        int bk, ra, wa;
        if (a == 5'd23) m_wr = w;
        if (a != 5'd20) return;
        bk = int'(w[12:11]); ra = int'(w[9:5]); wa = int'(w[4:0]);
        if (m_st == 4 && w[10]) begin
            if (w[15]) m_rd = (bk == 2) ? 16'h0 : m_mem[bk][ra];
            if (w[14] && bk != 2) m_mem[bk][wa] = m_wr;
        end else if (m_st == 4) m_st = (w == 0) ? 1 : 0;
        else if (w == 16'h0000) m_st = (m_st == 2) ? 3 : 1;
        else if (w == 16'h0400) m_st = (m_st == 1) ? 2 : (m_st == 3) ? 4 : 0;
        else m_st = 0;
        m_ctl = w;
    endtask

    function automatic logic [15:0] model_read(logic [4:0] a);
        case (a)
            5'd20:   return m_ctl;
            5'd21:   return m_rd;
            5'd23:   return m_wr;
            default: return 16'h0;
        endcase
    endfunction

    task automatic bus_wr(logic [4:0] a, logic [15:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, w);
    endtask

    task automatic check_rd(logic [4:0] a, string tag);
        logic [15:0] exp;
        reg_addr = a;
        #1;
        exp = model_read(a);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic unlock();
        bus_wr(5'd20, 16'h0000); bus_wr(5'd20, 16'h0400);
        bus_wr(5'd20, 16'h0000); bus_wr(5'd20, 16'h0400);
    endtask

    // Reads a bank register through the window and checks it
    task automatic peek(int bk, int r, string tag);
        bus_wr(5'd20, mk(1, 0, bk, 1, r, 0));
        check_rd(5'd21, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_rd(5'd20, "R1 ctl");
        check_rd(5'd21, "R1 rdwin");
        check_rd(5'd23, "R1 wrwin");

        // R6 window readback, R4 strobe while locked
        bus_wr(5'd23, 16'h1234);
        check_rd(5'd23, "R6 wrwin");
        bus_wr(5'd20, mk(0, 1, 1, 1, 0, 12));
        unlock();
        peek(1, 12, "R4 locked write dropped / R1 zero");

        // R5/R6 write then read
        bus_wr(5'd20, mk(0, 1, 1, 1, 0, 12));
        peek(1, 12, "R5 R6 readback");
        peek(1, 0, "R1 other reg zero");

        // R3 close with zero, R4 read while locked
        bus_wr(5'd20, 16'h0000);
        bus_wr(5'd20, mk(1, 0, 1, 1, 12, 0));
        check_rd(5'd21, "R4 read ignored when locked");
        check_rd(5'd20, "R9 ctl readback");

        // R2 broken sequence
        bus_wr(5'd20, 16'h0000); bus_wr(5'd20, 16'h0400);
        bus_wr(5'd20, 16'h0400); bus_wr(5'd20, 16'h0000);
        bus_wr(5'd20, 16'h0400);
        bus_wr(5'd20, mk(1, 0, 1, 1, 12, 0));
        check_rd(5'd21, "R2 broken pattern stays locked");
        unlock();
        peek(1, 12, "R2 full pattern opens");

        // R3 word without test mode locks
        peek(1, 0, "R5 reg0");
        bus_wr(5'd20, mk(1, 0, 1, 0, 12, 0));
        bus_wr(5'd20, mk(1, 0, 1, 1, 12, 0));
        check_rd(5'd21, "R3 no-tm word locks");

        // R8 empty bank
        unlock();
        peek(1, 12, "R5 reload");
        bus_wr(5'd23, 16'hBEEF);
        bus_wr(5'd20, mk(0, 1, 2, 1, 0, 3));
        peek(2, 3, "R8 bank2 reads zero");

        // R7 simultaneous read and write of same register
        bus_wr(5'd23, 16'h5A5A);
        bus_wr(5'd20, mk(1, 1, 3, 1, 7, 7));
        check_rd(5'd21, "R7 read sees old value");
        peek(3, 7, "R7 write landed");

        // R10 independence
        bus_wr(5'd23, 16'h1111);
        bus_wr(5'd20, mk(0, 1, 0, 1, 0, 12));
        peek(1, 12, "R10 bank1 untouched");
        peek(0, 12, "R10 bank0 written");

        // R9 ignored and unmapped addresses
        bus_wr(5'd21, 16'hFFFF);
        check_rd(5'd21, "R9 write to rdwin ignored");
        check_rd(5'd5, "R9 unmapped reads zero");

        // Random phase
        void'($urandom(32'h0051_7E57));
        for (int i = 0; i < 800; i++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0: bus_wr(5'd23, 16'($urandom));
                1: unlock();
                2: bus_wr(5'd20, ($urandom % 2) ? 16'h0000 : 16'h0400);
                3, 4, 5: bus_wr(5'd20, mk(1'($urandom), 1'($urandom), int'($urandom % 4),
                                          ($urandom % 8) != 0, int'($urandom % 32), int'($urandom % 32)));
                6: bus_wr(5'd20, 16'($urandom));
                default: bus_wr(5'($urandom), 16'($urandom));
            endcase
            check_rd(5'd21, "R5 R7 R8 random rdwin");
            if (op >= 6) check_rd(5'($urandom), "R9 random direct read");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule